// File: doc/BRIEF.md
# Selectable Pseudorandom Test Pattern Transmitter

This block is the transmit half of a bit-error-rate tester. On each cycle where the bit enable is high, it puts one test bit onto a serial output. Two selection inputs pick the pattern: a bank bit and a 3-bit code. The patterns are six maximal-length pseudorandom sequences (degrees 7, 9, 11, 15, 20 and 23), a zero-suppressed 2^20-1 sequence (QRSS), a repetitive pattern of programmable length cut from a loaded word, and an alternating pattern that sends a word and then its complement. A selection code with no assigned pattern raises a flag and silences the line.

Whenever the decoded selection changes, the generator restarts from a fixed all-ones seed. This means a given selection always produces the same bit sequence, so a matching receiver can lock to it. A transmit-invert control flips every outgoing bit. The output is registered and changes only on an enabled bit slot.

Top module: `prbs_pattern_gen`

## Requirements
- R1: With bank_i=0, sel_i codes 000, 001 and 010 select the degree-7 (x^7+x^6+1), degree-11 (x^11+x^9+1) and degree-15 (x^15+x^14+1) sequences. For a sequence of degree N with tap T, the emitted bit is register bit N-1. The register then shifts toward its MSB and takes bit(N-1) XOR bit(T-1) into bit 0.
- R2: With bank_i=1, sel_i codes 000, 001 and 010 select the degree-9 (x^9+x^5+1), plain degree-20 (x^20+x^17+1) and degree-23 (x^23+x^18+1) sequences, built as in R1.
- R3: With bank_i=0 and sel_i=011, the degree-20 register of R2 runs. Its emitted bit is forced to one when register bits 18 down to 5 (the next 14 bits to be sent) are all zero. The stream never holds more than 14 zeros in a row.
- R4: With bank_i=0 and sel_i=100, the block sends word_i bits 0 up to rep_len_i, LSB first. This gives rep_len_i+1 bits, repeated.
- R5: With bank_i=0 and sel_i=101, the block sends word_i bits 0..15 LSB first, then the complement of those bits in the same order, and repeats.
- R6: Bank 0 codes 110 and 111, and bank 1 codes 011 through 111, are illegal. For these, illegal_o is high in the same cycle, and data_o is cleared to 0 at every clock edge, whatever the bit enable.
- R7: With inv_i=1, every emitted bit is inverted. With inv_i=0, it passes unchanged.
- R8: On a clock edge where the decoded selection differs from the one last recorded, the register is reloaded with all ones and the word position and phase restart. No bit is emitted at that edge even if bit_en_i is high, and data_o holds (for a legal target).
- R9: At an edge with bit_en_i low and a legal selection, data_o holds and the sequence does not advance. The next enabled slot resumes the stream where it stopped.
- R10: Reset puts data_o at 0, loads the register with all ones and records bank 0 / code 000 as the current selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Emit one bit at this edge |
| bank_i | input | 1 | Pattern bank |
| sel_i | input | 3 | Pattern code within the bank |
| rep_len_i | input | 4 | Last bit index of the repetitive pattern |
| word_i | input | 16 | Pattern word for repetitive and alternating modes |
| inv_i | input | 1 | Invert the outgoing stream |
| data_o | output | 1 | Serial test bit (registered) |
| illegal_o | output | 1 | Current selection is illegal |

## Verification
A change of selection and a bit enable can land on the same edge. In that case the reseed must win, and the bit slot must be consumed without emitting anything. The bench provokes this on every pattern switch by keeping the bit enable high while it changes the selection. It then checks that data_o holds through that edge (or drops to zero for an illegal target). It also checks that the first enabled bit after that edge is the first bit of the freshly seeded sequence, as predicted by an independent model.

// File: rtl/prbs_pkg.sv
package prbs_pkg;

  typedef enum logic [3:0] {
    PM_P7, PM_P9, PM_P11, PM_P15, PM_P20, PM_QRSS, PM_P23, PM_REP, PM_ALT, PM_BAD
  } pat_mode_e;

  localparam int LFSR_W   = 23;
  localparam int NSEQ     = 6;
  localparam int SEQ_LEN [NSEQ] = '{7, 9, 11, 15, 20, 23};
  localparam int SEQ_TAP [NSEQ] = '{6, 5, 9, 14, 17, 18};
  localparam int QRSS_IDX = 4;
  localparam int QRSS_RUN = 14;
  localparam int QRSS_HI  = SEQ_LEN[QRSS_IDX] - 2;

  function automatic int seq_index(pat_mode_e m);
    case (m)
      PM_P7:           return 0;
      PM_P9:           return 1;
      PM_P11:          return 2;
      PM_P15:          return 3;
      PM_P20, PM_QRSS: return 4;
      PM_P23:          return 5;
      default:         return 0;
    endcase
  endfunction

  function automatic logic is_lfsr(pat_mode_e m);
    return (m != PM_REP) && (m != PM_ALT) && (m != PM_BAD);
  endfunction

endpackage

// File: rtl/prbs_sel_decode.sv
module prbs_sel_decode
  import prbs_pkg::*;
(
  input  logic       bank_i,
  input  logic [2:0] sel_i,
  output pat_mode_e  mode_o,
  output logic       illegal_o
);
  always_comb begin
    mode_o = PM_BAD;
    if (!bank_i) begin
      case (sel_i)
        3'b000:  mode_o = PM_P7;
        3'b001:  mode_o = PM_P11;
        3'b010:  mode_o = PM_P15;
        3'b011:  mode_o = PM_QRSS;
        3'b100:  mode_o = PM_REP;
        3'b101:  mode_o = PM_ALT;
        default: mode_o = PM_BAD;
      endcase
    end else begin
      case (sel_i)
        3'b000:  mode_o = PM_P9;
        3'b001:  mode_o = PM_P20;
        3'b010:  mode_o = PM_P23;
        default: mode_o = PM_BAD;
      endcase
    end
    illegal_o = (mode_o == PM_BAD);
  end
endmodule

// File: rtl/prbs_lfsr.sv
module prbs_lfsr
  import prbs_pkg::*;
#(
  parameter int W = LFSR_W
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      seed_i,
  input  logic      step_i,
  input  pat_mode_e mode_i,
  output logic      bit_o
);
  logic [W-1:0]    state_q, state_d, mask;
  logic [NSEQ-1:0] out_c, fb_c;
  int              sidx;

  for (genvar g = 0; g < NSEQ; g++) begin : g_seq
    assign out_c[g] = state_q[SEQ_LEN[g]-1];
    assign fb_c[g]  = state_q[SEQ_LEN[g]-1] ^ state_q[SEQ_TAP[g]-1];
  end

  always_comb begin
    sidx = seq_index(mode_i);
    for (int i = 0; i < W; i++) mask[i] = (i < SEQ_LEN[sidx]);
  end

  // zero suppression looks ahead at the next QRSS_RUN bits to be sent
  always_comb begin
    bit_o = out_c[sidx];
    if (mode_i == PM_QRSS && state_q[QRSS_HI -: QRSS_RUN] == '0) bit_o = 1'b1;
  end

  always_comb begin
    state_d = state_q;
    if (seed_i)      state_d = mask;
    else if (step_i) state_d = {state_q[W-2:0], fb_c[sidx]} & mask;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= '1;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/prbs_word_seq.sv
module prbs_word_seq #(
  parameter int WORD_W = 16,
  localparam int IDX_W = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              step_i,
  input  logic              alt_i,
  input  logic [IDX_W-1:0]  rep_len_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              bit_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(WORD_W - 1);

  logic [IDX_W-1:0] idx_q;
  logic             phase_q;

  assign bit_o = word_i[idx_q] ^ (alt_i & phase_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      phase_q <= 1'b0;
    end else if (clear_i) begin
      idx_q   <= '0;
      phase_q <= 1'b0;
    end else if (step_i) begin
      if (alt_i) begin
        idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
        if (idx_q == LAST) phase_q <= ~phase_q;
      end else begin
        idx_q   <= (idx_q >= rep_len_i) ? '0 : idx_q + 1'b1;
        phase_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/prbs_pattern_gen.sv
module prbs_pattern_gen
  import prbs_pkg::*;
#(
  parameter int WORD_W = 16,
  localparam int LEN_W = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              bank_i,
  input  logic [2:0]        sel_i,
  input  logic [LEN_W-1:0]  rep_len_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              inv_i,
  output logic              data_o,
  output logic              illegal_o
);
  pat_mode_e mode_d, mode_q;
  logic      sel_change, emit, lfsr_bit, word_bit, next_bit;

  prbs_sel_decode u_dec (
    .bank_i    (bank_i),
    .sel_i     (sel_i),
    .mode_o    (mode_d),
    .illegal_o (illegal_o)
  );

  assign sel_change = (mode_d != mode_q);
  assign emit       = bit_en_i && !sel_change && !illegal_o;

  prbs_lfsr #(.W(LFSR_W)) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .seed_i (sel_change),
    .step_i (emit && is_lfsr(mode_d)),
    .mode_i (mode_d),
    .bit_o  (lfsr_bit)
  );

  prbs_word_seq #(.WORD_W(WORD_W)) u_word (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (sel_change),
    .step_i    (emit && !is_lfsr(mode_d)),
    .alt_i     (mode_d == PM_ALT),
    .rep_len_i (rep_len_i),
    .word_i    (word_i),
    .bit_o     (word_bit)
  );

  assign next_bit = (is_lfsr(mode_d) ? lfsr_bit : word_bit) ^ inv_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= PM_P7;
      data_o <= 1'b0;
    end else begin
      mode_q <= mode_d;
      if (illegal_o) data_o <= 1'b0;
      else if (emit) data_o <= next_bit;
    end
  end
endmodule

// File: rtl/prbs_pattern_gen_chk.sv
module prbs_pattern_gen_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bit_en_i,
  input logic       bank_i,
  input logic [2:0] sel_i,
  input logic       inv_i,
  input logic       data_o,
  input logic       illegal_o,
  input logic       sel_change
);
  logic       qrss_emit_q;
  logic [4:0] zrun_q;
  logic       qrss_sel;

  assign qrss_sel = !bank_i && (sel_i == 3'b011);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      qrss_emit_q <= 1'b0;
      zrun_q      <= '0;
    end else begin
      qrss_emit_q <= bit_en_i && !sel_change && qrss_sel && !inv_i;
      if (!qrss_sel || sel_change) zrun_q <= '0;
      else if (qrss_emit_q) zrun_q <= data_o ? 5'd0 : ((zrun_q == 5'd31) ? zrun_q : zrun_q + 5'd1);
    end
  end

  // R6
  illegal_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> !data_o);

  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bit_en_i && !illegal_o) |=> $stable(data_o));

  // R8
  change_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_change && !illegal_o) |=> $stable(data_o));

  // R3
  qrss_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zrun_q <= 5'd14);
endmodule

bind prbs_pattern_gen prbs_pattern_gen_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bit_en_i   (bit_en_i),
  .bank_i     (bank_i),
  .sel_i      (sel_i),
  .inv_i      (inv_i),
  .data_o     (data_o),
  .illegal_o  (illegal_o),
  .sel_change (sel_change)
);

// File: tb/prbs_pattern_gen_tb.sv
`timescale 1ns/1ps
module prbs_pattern_gen_tb;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        bit_en_i = 1'b0, bank_i = 1'b0, inv_i = 1'b0;
  logic [2:0]  sel_i = 3'b000;
  logic [3:0]  rep_len_i = '0;
  logic [15:0] word_i = '0;
  logic        data_o, illegal_o;
  int          checks = 0, failures = 0;

  always #2.5 clk_i = ~clk_i;

  prbs_pattern_gen u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_en_i(bit_en_i), .bank_i(bank_i),
    .sel_i(sel_i), .rep_len_i(rep_len_i), .word_i(word_i), .inv_i(inv_i),
    .data_o(data_o), .illegal_o(illegal_o)
  );

  // {bank, sel, len, word, inv, nbits, exp_illegal}
  localparam int NV = 14;
  localparam logic [33:0] VEC [NV] = '{
    {1'b0, 3'd1, 4'd0,  16'h0000, 1'b0, 8'd200, 1'b0},  // R1 deg 11
    {1'b0, 3'd0, 4'd0,  16'h0000, 1'b1, 8'd150, 1'b0},  // R1 deg 7, R7 inverted
    {1'b1, 3'd0, 4'd0,  16'h0000, 1'b0, 8'd200, 1'b0},  // R2 deg 9
    {1'b0, 3'd2, 4'd0,  16'h0000, 1'b0, 8'd200, 1'b0},  // R1 deg 15
    {1'b1, 3'd1, 4'd0,  16'h0000, 1'b0, 8'd200, 1'b0},  // R2 deg 20
    {1'b1, 3'd2, 4'd0,  16'h0000, 1'b1, 8'd200, 1'b0},  // R2 deg 23, R7
    {1'b0, 3'd3, 4'd0,  16'h0000, 1'b0, 8'd200, 1'b0},  // R3 QRSS
    {1'b0, 3'd4, 4'd4,  16'h005A, 1'b0, 8'd40,  1'b0},  // R4 five bits
    {1'b0, 3'd6, 4'd0,  16'h0000, 1'b0, 8'd10,  1'b1},  // R6
    {1'b0, 3'd5, 4'd0,  16'hC3A5, 1'b0, 8'd100, 1'b0},  // R5
    {1'b1, 3'd3, 4'd0,  16'h0000, 1'b1, 8'd10,  1'b1},  // R6 with invert
    {1'b0, 3'd4, 4'd15, 16'hBEEF, 1'b1, 8'd60,  1'b0},  // R4 full word, R7
    {1'b1, 3'd7, 4'd0,  16'h0000, 1'b0, 8'd10,  1'b1},  // R6
    {1'b0, 3'd0, 4'd0,  16'h0000, 1'b0, 8'd254, 1'b0}   // R1 deg 7
  };

  // reference model, built from R1..R5 and R7
  logic [22:0] m_st;
  int          m_len, m_tap, m_kind;  // kind: 0 lfsr, 1 qrss, 2 rep, 3 alt
  int          m_idx;
  logic        m_phase;
  int          m_forced;

  task automatic model_seed(input logic b, input logic [2:0] s);
    m_kind = 0; m_len = 7; m_tap = 6;
    if (!b) begin
      case (s)
        3'd0: begin m_len = 7;  m_tap = 6;  end
        3'd1: begin m_len = 11; m_tap = 9;  end
        3'd2: begin m_len = 15; m_tap = 14; end
        3'd3: begin m_len = 20; m_tap = 17; m_kind = 1; end
        3'd4: m_kind = 2;
        default: m_kind = 3;
      endcase
    end else begin
      case (s)
        3'd0:    begin m_len = 9;  m_tap = 5;  end
        3'd1:    begin m_len = 20; m_tap = 17; end
        default: begin m_len = 23; m_tap = 18; end
      endcase
    end
    m_st = '0;
    for (int i = 0; i < m_len; i++) m_st[i] = 1'b1;
    m_idx = 0; m_phase = 1'b0;
  endtask

  function automatic logic model_bit(input logic [3:0] len, input logic [15:0] w, input logic inv);
    logic b, fb;
    if (m_kind <= 1) begin
      b = m_st[m_len-1];
      if (m_kind == 1 && m_st[18:5] == 14'd0) begin
        if (!b) m_forced++;
        b = 1'b1;
      end
      fb = m_st[m_len-1] ^ m_st[m_tap-1];
      m_st = {m_st[21:0], fb};
      for (int i = m_len; i < 23; i++) m_st[i] = 1'b0;
    end else if (m_kind == 2) begin
      b = w[m_idx];
      m_idx = (m_idx >= int'(len)) ? 0 : m_idx + 1;
    end else begin
      b = w[m_idx] ^ m_phase;
      if (m_idx == 15) begin m_idx = 0; m_phase = ~m_phase; end
      else m_idx++;
    end
    return b ^ inv;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic d0;
    int   bad, zrun, zmax;
    repeat (3) @(negedge clk_i);
    check("R10 data_o in reset", 32'(data_o), 32'd0);
    check("R10 illegal_o in reset", 32'(illegal_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int v = 0; v < NV; v++) begin
      logic [33:0] e;
      e = VEC[v];
      d0 = data_o;
      bank_i = e[33]; sel_i = e[32:30]; rep_len_i = e[29:26];
      word_i = e[25:10]; inv_i = e[9]; bit_en_i = 1'b1;
      @(negedge clk_i);
      // R8: change and enable on the same edge, reseed wins
      check("R6 illegal flag", 32'(illegal_o), 32'(e[0]));
      check("R8 no bit on change edge", 32'(data_o), e[0] ? 32'd0 : 32'(d0));
      model_seed(e[33], e[32:30]);
      bad = 0;
      for (int n = 0; n < int'(e[8:1]); n++) begin
        logic exp_b;
        @(negedge clk_i);
        exp_b = e[0] ? 1'b0 : model_bit(e[29:26], e[25:10], e[9]);
        if (data_o !== exp_b) begin
          if (bad == 0) $display("FAIL vec %0d bit %0d actual=%0b expected=%0b", v, n, data_o, exp_b);
          bad++;
        end
      end
      check(e[0] ? "R6 zero output" : "R1 R2 R3 R4 R5 R7 stream", 32'(bad), 32'd0);
    end

    // R9: enable low holds output and pauses the sequence (still deg 7 from last vector)
    bit_en_i = 1'b0;
    d0 = data_o;
    repeat (5) @(negedge clk_i);
    check("R9 hold with enable low", 32'(data_o), 32'(d0));
    bit_en_i = 1'b1;
    bad = 0;
    for (int n = 0; n < 20; n++) begin
      logic exp_b;
      @(negedge clk_i);
      exp_b = model_bit(4'd0, 16'h0, 1'b0);
      if (data_o !== exp_b) bad++;
    end
    check("R9 resume after pause", 32'(bad), 32'd0);

    // R6: illegal clears even without enable
    bit_en_i = 1'b0; bank_i = 1'b1; sel_i = 3'd5;
    @(negedge clk_i);
    check("R6 cleared without enable", 32'(data_o), 32'd0);

    // R3: long QRSS run, zero-run bound and model agreement
    bank_i = 1'b0; sel_i = 3'd3; inv_i = 1'b0; bit_en_i = 1'b1;
    @(negedge clk_i);
    model_seed(1'b0, 3'd3);
    m_forced = 0; bad = 0; zrun = 0; zmax = 0;
    for (int n = 0; n < 120000; n++) begin
      logic exp_b;
      @(negedge clk_i);
      exp_b = model_bit(4'd0, 16'h0, 1'b0);
      if (data_o !== exp_b) begin
        if (bad == 0) $display("FAIL R3 qrss bit %0d actual=%0b expected=%0b", n, data_o, exp_b);
        bad++;
      end
      zrun = data_o ? 0 : zrun + 1;
      if (zrun > zmax) zmax = zrun;
    end
    check("R3 qrss stream", 32'(bad), 32'd0);
    check("R3 zero run bound", 32'(zmax > 14), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule